// File: doc/BRIEF.md
# Unaligned Operand Bus Splitter

This block sits between a processor's load/store request port and a 32-bit big-endian external data bus. A request carries a byte address, an operand size (byte, word or longword), a read/write flag, an instruction-fetch flag and write data. Data operands may start at any byte address. When an operand does not sit on its natural boundary, the block breaks it into the shortest series of naturally aligned bus cycles. For each cycle it presents the address, size, byte-lane enables and lane-steered write data. For reads it gathers the returned bytes into one right-justified result.

Each bus cycle uses a valid/ready handshake. The splitter keeps its request port busy until the last transfer of the current operand is acknowledged. One cycle after that final acknowledge it pulses a completion flag with the result. An instruction fetch at an odd address never reaches the bus. It raises an address-error pulse instead.

Top module: `unaligned_bus_splitter`

## Requirements
- R1: After synchronous reset, req_ready is 1 and bus_valid, done and addr_err are 0.
- R2: Size codes on req_size and bus_size are 0 = byte (1 byte), 1 = word (2 bytes), 2 = longword (4 bytes), and a request size of 3 is treated as a longword. The byte at address offset o (bus_addr[1:0]) uses lane bus_be[3-o], and that lane is bus_wdata/bus_rdata bits 31-8o down to 24-8o. During a bus cycle, bus_be holds exactly as many ones as the size code calls for, starting at the lane of bus_addr.
- R3: A naturally aligned operand is done in one bus cycle whose address, size and lanes are those of the request.
- R4: Transfers are chosen greedily from the current byte address a with r bytes remaining. If a mod 4 = 0 and r >= 4, the transfer is a longword. Otherwise, if a is even and r >= 2, it is a word. Otherwise it is a byte. A longword at offset 1 therefore takes byte@1, word@2, byte@4. A longword at offset 2 takes word@2, word@4. A longword at offset 3 takes byte@3, word@4, byte@6.
- R5: A word at an odd address is done in exactly two byte transfers.
- R6: Operand bytes are big-endian: the most significant byte goes to the lowest address. On writes, each operand byte is driven on the lane of its address, and lanes that are not enabled carry zero.
- R7: One cycle after the acknowledge of the final transfer, done is 1 for one cycle. For a read, done_rdata then holds the operand right-justified. For a write, done_rdata is 0.
- R8: While bus_valid is 1 and bus_ready is 0, bus_valid, bus_addr, bus_size, bus_be and bus_wdata hold their values. The next transfer starts only after an acknowledge.
- R9: req_ready is 0 from the cycle after a request is accepted until the cycle in which done is 1. A request offered during that time is not taken.
- R10: A request with req_ifetch = 1 and an odd address starts no bus cycle and gives no done. It gives a one-cycle addr_err pulse in the cycle after acceptance. An odd data address raises no error. An instruction fetch is always a read.
- R11: No transfer crosses its natural boundary: a word transfer has bus_addr[0] = 0, and a longword transfer has bus_addr[1:0] = 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Request offered |
| req_ready | output | 1 | Splitter idle and able to take a request |
| req_addr | input | ADDR_W | Operand byte address |
| req_size | input | 2 | Operand size code |
| req_write | input | 1 | 1 = store, 0 = load |
| req_ifetch | input | 1 | Request is an instruction fetch |
| req_wdata | input | 32 | Right-justified store operand |
| bus_valid | output | 1 | Bus cycle requested |
| bus_ready | input | 1 | Bus acknowledge of the current cycle |
| bus_addr | output | ADDR_W | Byte address of the current transfer |
| bus_size | output | 2 | Size code of the current transfer |
| bus_be | output | 4 | Byte-lane enables, bit 3 = offset 0 |
| bus_write | output | 1 | Current transfer is a write |
| bus_wdata | output | 32 | Lane-steered write data |
| bus_rdata | input | 32 | Read data returned with bus_ready |
| done | output | 1 | Operand completed |
| done_rdata | output | 32 | Right-justified read result |
| addr_err | output | 1 | Odd instruction-fetch address |

## Verification
Completion of one operand can fall in the same cycle as the offer of the next one. In the cycle where done pulses, req_ready is already high. The bench presents every following request in exactly that cycle, with no idle gap, across a long chain of random and directed operands. Each such overlap is judged on two points: the done_rdata of the finishing operand must match the bench memory model, and the first bus cycle of the new operand must carry the address, size, lanes and data that the greedy splitting rule predicts. Random acknowledge stalls also move the final acknowledge to different points relative to those overlaps.

// File: rtl/ubs_pkg.sv
package ubs_pkg;

    localparam int DATA_W = 32;
    localparam int BYTE_W = 8;
    localparam int LANES  = DATA_W / BYTE_W;

    typedef enum logic [1:0] {
        SZ_BYTE = 2'd0,
        SZ_WORD = 2'd1,
        SZ_LONG = 2'd2
    } xfer_size_e;

    typedef enum logic {
        ST_IDLE = 1'b0,
        ST_XFER = 1'b1
    } seq_state_e;

    typedef struct packed {
        logic [2:0] nbytes;
        xfer_size_e sz;
    } step_t;

    // Operand length in bytes for a request size code (3 acts as longword).
    function automatic logic [2:0] operand_len(input logic [1:0] code);
        case (code)
            2'd0:    operand_len = 3'd1;
            2'd1:    operand_len = 3'd2;
            default: operand_len = 3'd4;
        endcase
    endfunction

    // Largest naturally aligned transfer that fits at this offset.
    function automatic step_t pick_step(input logic [1:0] off, input logic [2:0] rem);
        step_t s;
        if (off == 2'd0 && rem >= 3'd4) begin
            s.nbytes = 3'd4;
            s.sz     = SZ_LONG;
        end else if (!off[0] && rem >= 3'd2) begin
            s.nbytes = 3'd2;
            s.sz     = SZ_WORD;
        end else begin
            s.nbytes = 3'd1;
            s.sz     = SZ_BYTE;
        end
        return s;
    endfunction

    // Lane enables: offset i maps to bit LANES-1-i.
    function automatic logic [LANES-1:0] lane_mask(input logic [1:0] off, input logic [2:0] n);
        logic [LANES-1:0] m;
        for (int i = 0; i < LANES; i++) begin
            m[LANES-1-i] = (i >= int'(off)) && (i < int'(off) + int'(n));
        end
        return m;
    endfunction

endpackage

// File: rtl/ubs_wr_steer.sv
module ubs_wr_steer
    import ubs_pkg::*;
(
    input  logic [DATA_W-1:0] operand,
    input  logic [2:0]        total_len,
    input  logic [2:0]        sent_cnt,
    input  logic [1:0]        off,
    input  logic [LANES-1:0]  lane_en,
    output logic [DATA_W-1:0] lane_data
);

    for (genvar L = 0; L < LANES; L++) begin : g_lane
        logic [BYTE_W-1:0] lane_b;
        always_comb begin
            int j;
            int pos;
            j      = int'(sent_cnt) + L - int'(off);
            pos    = int'(total_len) - 1 - j;
            lane_b = '0;
            if (lane_en[LANES-1-L] && pos >= 0 && pos < LANES) begin
                lane_b = operand[pos*BYTE_W +: BYTE_W];
            end
        end
        assign lane_data[DATA_W-1-BYTE_W*L -: BYTE_W] = lane_b;
    end

endmodule

// File: rtl/ubs_rd_merge.sv
module ubs_rd_merge
    import ubs_pkg::*;
(
    input  logic [DATA_W-1:0] acc_in,
    input  logic [DATA_W-1:0] lane_data,
    input  logic [2:0]        total_len,
    input  logic [2:0]        recv_cnt,
    input  logic [1:0]        off,
    input  logic [LANES-1:0]  lane_en,
    output logic [DATA_W-1:0] acc_out
);

    always_comb begin
        acc_out = acc_in;
        for (int L = 0; L < LANES; L++) begin
            int j;
            int pos;
            j   = int'(recv_cnt) + L - int'(off);
            pos = int'(total_len) - 1 - j;
            if (lane_en[LANES-1-L] && pos >= 0 && pos < LANES) begin
                acc_out[pos*BYTE_W +: BYTE_W] = lane_data[DATA_W-1-BYTE_W*L -: BYTE_W];
            end
        end
    end

endmodule

// File: rtl/unaligned_bus_splitter.sv
module unaligned_bus_splitter
    import ubs_pkg::*;
#(
    parameter int ADDR_W = 32
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              req_valid,
    output logic              req_ready,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic [1:0]        req_size,
    input  logic              req_write,
    input  logic              req_ifetch,
    input  logic [31:0]       req_wdata,
    output logic              bus_valid,
    input  logic              bus_ready,
    output logic [ADDR_W-1:0] bus_addr,
    output logic [1:0]        bus_size,
    output logic [3:0]        bus_be,
    output logic              bus_write,
    output logic [31:0]       bus_wdata,
    input  logic [31:0]       bus_rdata,
    output logic              done,
    output logic [31:0]       done_rdata,
    output logic              addr_err
);

    seq_state_e        state_q;
    logic [ADDR_W-1:0] cur_addr_q;
    logic [2:0]        rem_q;
    logic [2:0]        moved_q;
    logic [2:0]        total_q;
    logic [DATA_W-1:0] operand_q;
    logic [DATA_W-1:0] acc_q;
    logic              write_q;
    logic              done_q;
    logic              err_q;
    logic [DATA_W-1:0] result_q;

    step_t             step;
    logic [LANES-1:0]  cur_be;
    logic [DATA_W-1:0] steered;
    logic [DATA_W-1:0] merged;
    logic              accept;
    logic              ack;
    logic              last_xfer;

    assign step      = pick_step(cur_addr_q[1:0], rem_q);
    assign cur_be    = lane_mask(cur_addr_q[1:0], step.nbytes);
    assign accept    = req_valid && (state_q == ST_IDLE);
    assign ack       = (state_q == ST_XFER) && bus_ready;
    assign last_xfer = (rem_q == step.nbytes);

    ubs_wr_steer u_wr_steer (
        .operand   (operand_q),
        .total_len (total_q),
        .sent_cnt  (moved_q),
        .off       (cur_addr_q[1:0]),
        .lane_en   (cur_be),
        .lane_data (steered)
    );

    ubs_rd_merge u_rd_merge (
        .acc_in    (acc_q),
        .lane_data (bus_rdata),
        .total_len (total_q),
        .recv_cnt  (moved_q),
        .off       (cur_addr_q[1:0]),
        .lane_en   (cur_be),
        .acc_out   (merged)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q    <= ST_IDLE;
            cur_addr_q <= '0;
            rem_q      <= '0;
            moved_q    <= '0;
            total_q    <= '0;
            operand_q  <= '0;
            acc_q      <= '0;
            write_q    <= 1'b0;
            done_q     <= 1'b0;
            err_q      <= 1'b0;
            result_q   <= '0;
        end else begin
            done_q <= 1'b0;
            err_q  <= 1'b0;
            if (accept) begin
                if (req_ifetch && req_addr[0]) begin
                    err_q <= 1'b1;
                end else begin
                    state_q    <= ST_XFER;
                    cur_addr_q <= req_addr;
                    total_q    <= operand_len(req_size);
                    rem_q      <= operand_len(req_size);
                    moved_q    <= '0;
                    operand_q  <= req_wdata;
                    acc_q      <= '0;
                    write_q    <= req_write && !req_ifetch;
                end
            end else if (ack) begin
                cur_addr_q <= cur_addr_q + ADDR_W'(step.nbytes);
                rem_q      <= rem_q - step.nbytes;
                moved_q    <= moved_q + step.nbytes;
                if (!write_q) begin
                    acc_q <= merged;
                end
                if (last_xfer) begin
                    state_q  <= ST_IDLE;
                    done_q   <= 1'b1;
                    result_q <= write_q ? '0 : merged;
                end
            end
        end
    end

    assign req_ready  = (state_q == ST_IDLE);
    assign bus_valid  = (state_q == ST_XFER);
    assign bus_addr   = cur_addr_q;
    assign bus_size   = step.sz;
    assign bus_be     = bus_valid ? cur_be : '0;
    assign bus_write  = bus_valid && write_q;
    assign bus_wdata  = (bus_valid && write_q) ? steered : '0;
    assign done       = done_q;
    assign done_rdata = result_q;
    assign addr_err   = err_q;

endmodule

// File: rtl/ubs_chk.sv
module ubs_chk #(
    parameter int ADDR_W = 32
) (
    input logic              clk,
    input logic              rst,
    input logic              req_ready,
    input logic              bus_valid,
    input logic              bus_ready,
    input logic [ADDR_W-1:0] bus_addr,
    input logic [1:0]        bus_size,
    input logic [3:0]        bus_be,
    input logic [31:0]       bus_wdata,
    input logic              done,
    input logic              addr_err
);

    AST_BUSY_NO_REQ: assert property (@(posedge clk) disable iff (rst)
        bus_valid |-> !req_ready); // R9

    AST_HOLD_ON_STALL: assert property (@(posedge clk) disable iff (rst)
        (bus_valid && !bus_ready) |=> (bus_valid && $stable(bus_addr) && $stable(bus_be)
                                       && $stable(bus_size) && $stable(bus_wdata))); // R8

    AST_LANE_COUNT: assert property (@(posedge clk) disable iff (rst)
        bus_valid |-> ($countones(bus_be) == ((bus_size == 2'd0) ? 1 : (bus_size == 2'd1) ? 2 : 4))); // R2

    AST_FIRST_LANE: assert property (@(posedge clk) disable iff (rst)
        bus_valid |-> bus_be[3 - bus_addr[1:0]]); // R2

    AST_WORD_ALIGNED: assert property (@(posedge clk) disable iff (rst)
        (bus_valid && bus_size == 2'd1) |-> !bus_addr[0]); // R11

    AST_LONG_ALIGNED: assert property (@(posedge clk) disable iff (rst)
        (bus_valid && bus_size == 2'd2) |-> (bus_addr[1:0] == 2'd0)); // R11

    AST_ERR_NO_BUS: assert property (@(posedge clk) disable iff (rst)
        addr_err |-> (!bus_valid && !done)); // R10

    AST_DONE_AFTER_ACK: assert property (@(posedge clk) disable iff (rst)
        done |-> $past(bus_valid && bus_ready)); // R7

    AST_DONE_ONE_CYCLE: assert property (@(posedge clk) disable iff (rst)
        done |=> !done); // R7

endmodule

bind unaligned_bus_splitter ubs_chk #(.ADDR_W(ADDR_W)) u_chk (.*);

// File: tb/tb_unaligned_bus_splitter.sv
module tb_unaligned_bus_splitter;

    logic        clk = 1'b0;
    logic        rst;
    logic        req_valid;
    logic        req_ready;
    logic [31:0] req_addr;
    logic [1:0]  req_size;
    logic        req_write;
    logic        req_ifetch;
    logic [31:0] req_wdata;
    logic        bus_valid;
    logic        bus_ready;
    logic [31:0] bus_addr;
    logic [1:0]  bus_size;
    logic [3:0]  bus_be;
    logic        bus_write;
    logic [31:0] bus_wdata;
    logic [31:0] bus_rdata;
    logic        done;
    logic [31:0] done_rdata;
    logic        addr_err;

    int total = 0;
    int bad   = 0;
    logic [7:0] mem [64];

    always #2.5 clk = ~clk;

    unaligned_bus_splitter #(.ADDR_W(32)) dut (.*);

    task automatic chk(input bit ok, input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
        end
    endtask

    function automatic int len_of(input logic [1:0] code);
        return (code == 2'd0) ? 1 : (code == 2'd1) ? 2 : 4;
    endfunction

    // Called at a negedge with the splitter idle; returns at a negedge.
    task automatic do_op(input logic [31:0] addr, input logic [1:0] sz, input bit wr,
                         input bit ifetch, input logic [31:0] wd);
        logic [31:0] e_addr [3];
        logic [1:0]  e_sz   [3];
        logic [3:0]  e_be   [3];
        logic [31:0] e_wd   [3];
        logic [31:0] exp_rd;
        int n, a, k, cnt;
        bit eff_wr;
        n = len_of(sz);
        eff_wr = wr && !ifetch;
        a = int'(addr); k = 0; cnt = 0;
        while (k < n) begin
            int s;
            if (a % 4 == 0 && n - k >= 4) s = 4;
            else if (a % 2 == 0 && n - k >= 2) s = 2;
            else s = 1;
            e_addr[cnt] = 32'(a);
            e_sz[cnt]   = (s == 4) ? 2'd2 : (s == 2) ? 2'd1 : 2'd0;
            e_be[cnt]   = '0;
            e_wd[cnt]   = '0;
            for (int i = 0; i < s; i++) begin
                int ln;
                ln = (a + i) % 4;
                e_be[cnt][3-ln] = 1'b1;
                if (eff_wr) e_wd[cnt][31-8*ln -: 8] = wd[(n-1-(k+i))*8 +: 8];
            end
            a += s; k += s; cnt++;
        end
        exp_rd = '0;
        for (int j = 0; j < n; j++) exp_rd[(n-1-j)*8 +: 8] = mem[(int'(addr) + j) % 64];

        chk(req_ready == 1'b1, "R9", "ready when idle", {31'd0, req_ready}, 32'd1);
        req_valid = 1'b1; req_addr = addr; req_size = sz; req_write = wr;
        req_ifetch = ifetch; req_wdata = wd;
        @(posedge clk); @(negedge clk);
        req_valid = 1'b0;

        if (ifetch && addr[0]) begin
            chk(addr_err == 1'b1 && bus_valid == 1'b0 && done == 1'b0, "R10",
                "odd fetch error", {29'd0, addr_err, bus_valid, done}, 32'b100);
            return;
        end
        chk(addr_err == 1'b0, "R10", "no error", {31'd0, addr_err}, 32'd0);
        chk(req_ready == 1'b0, "R9", "busy after accept", {31'd0, req_ready}, 32'd0);

        for (int t = 0; t < cnt; t++) begin
            int d;
            chk(bus_valid == 1'b1, "R8", "bus_valid", {31'd0, bus_valid}, 32'd1);
            chk(bus_addr == e_addr[t], (n == 2 && addr[0]) ? "R5" : "R4", "bus_addr",
                bus_addr, e_addr[t]);
            chk(bus_size == e_sz[t] && bus_be == e_be[t], "R2", "size/be",
                {26'd0, bus_size, bus_be}, {26'd0, e_sz[t], e_be[t]});
            chk(bus_write == eff_wr, "R10", "direction", {31'd0, bus_write}, {31'd0, eff_wr});
            if (eff_wr) chk(bus_wdata == e_wd[t], "R6", "bus_wdata", bus_wdata, e_wd[t]);
            d = int'($urandom_range(0, 2));
            for (int w = 0; w < d; w++) begin
                req_valid = 1'b1;  // offered while busy; must not be taken
                @(posedge clk); @(negedge clk);
                req_valid = 1'b0;
                chk(bus_addr == e_addr[t] && bus_be == e_be[t], "R8", "hold on stall",
                    bus_addr, e_addr[t]);
            end
            bus_rdata = '0;
            for (int L = 0; L < 4; L++) bus_rdata[31-8*L -: 8] = mem[{bus_addr[5:2], 2'(L)}];
            if (bus_write)
                for (int L = 0; L < 4; L++)
                    if (bus_be[3-L]) mem[{bus_addr[5:2], 2'(L)}] = bus_wdata[31-8*L -: 8];
            bus_ready = 1'b1;
            @(posedge clk); @(negedge clk);
            bus_ready = 1'b0;
            if (t < cnt - 1) chk(done == 1'b0, "R7", "no early done", {31'd0, done}, 32'd0);
        end
        if (cnt == 1) chk(len_of(sz) == 1 || addr % n == 0, "R3", "single cycle aligned",
                          32'(cnt), 32'd1);
        chk(done == 1'b1 && req_ready == 1'b1 && bus_valid == 1'b0, "R7", "done pulse",
            {29'd0, done, req_ready, bus_valid}, 32'b110);
        chk(done_rdata == (eff_wr ? 32'd0 : exp_rd), "R7", "done_rdata", done_rdata,
            eff_wr ? 32'd0 : exp_rd);
        if (eff_wr) begin
            logic [31:0] got;
            got = '0;
            for (int j = 0; j < n; j++) got[(n-1-j)*8 +: 8] = mem[(int'(addr) + j) % 64];
            chk(got == (wd & ((n == 4) ? 32'hFFFF_FFFF : (n == 2) ? 32'h0000_FFFF : 32'h0000_00FF)),
                "R6", "stored bytes", got, wd);
        end
    endtask

    initial begin : watchdog
        repeat (150000) @(posedge clk);
        bad++; total++;
        $display("FAIL watchdog expired");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        void'($urandom(32'd4242));
        for (int i = 0; i < 64; i++) mem[i] = 8'(i * 37 + 11);
        rst = 1'b1; req_valid = 1'b0; req_addr = '0; req_size = '0; req_write = 1'b0;
        req_ifetch = 1'b0; req_wdata = '0; bus_ready = 1'b0; bus_rdata = '0;
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;
        chk(req_ready == 1'b1 && bus_valid == 1'b0 && done == 1'b0 && addr_err == 1'b0,
            "R1", "reset state", {28'd0, req_ready, bus_valid, done, addr_err}, 32'b1000);
        @(negedge clk);

        do_op(32'h0000_0001, 2'd2, 1'b0, 1'b0, 32'h0);            // R4 long @1 read
        do_op(32'h0000_0011, 2'd2, 1'b1, 1'b0, 32'hA1B2_C3D4);    // R4 R6 long @1 write
        do_op(32'h0000_0022, 2'd2, 1'b0, 1'b0, 32'h0);            // R4 long @2
        do_op(32'h0000_0033, 2'd2, 1'b1, 1'b0, 32'h1122_3344);    // R4 long @3
        do_op(32'h0000_0005, 2'd1, 1'b0, 1'b0, 32'h0);            // R5 word @1
        do_op(32'h0000_0017, 2'd1, 1'b1, 1'b0, 32'h0000_BEEF);    // R5 word @3
        do_op(32'h0000_0008, 2'd2, 1'b0, 1'b0, 32'h0);            // R3 aligned long
        do_op(32'h0000_000A, 2'd1, 1'b1, 1'b0, 32'h0000_5A5A);    // R3 aligned word
        do_op(32'h0000_0027, 2'd0, 1'b1, 1'b0, 32'h0000_00C7);    // R3 byte @3
        do_op(32'h0000_0015, 2'd3, 1'b0, 1'b0, 32'h0);            // R2 size 3 as long
        do_op(32'h0000_0003, 2'd1, 1'b0, 1'b1, 32'h0);            // R10 odd fetch
        do_op(32'h0000_0006, 2'd2, 1'b1, 1'b1, 32'hFFFF_FFFF);    // R10 even fetch reads
        do_op(32'h0000_0009, 2'd1, 1'b0, 1'b0, 32'h0);            // R10 odd data no error

        for (int r = 0; r < 400; r++) begin
            logic [31:0] ad;
            ad = {26'd0, 6'($urandom_range(0, 60))};
            do_op(ad, 2'($urandom_range(0, 3)), 1'($urandom_range(0, 1)),
                  ($urandom_range(0, 9) == 0), $urandom);
        end

        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule